// File: doc/BRIEF.md
# Integer ALU With Condition Code

This block is a 32-bit integer execution unit that takes one operation per clock. It does signed and unsigned addition and subtraction, and four bitwise operations: AND, AND with an inverted first operand, and the two "high" forms of these that place a 16-bit constant in the upper half of the word. The first operand comes either from a register input or from a 16-bit immediate. The immediate is sign-extended for arithmetic and zero-extended for bitwise operations. The result, an overflow flag and a one-bit condition code are registered and appear after the next rising clock edge.

The condition code has a different meaning for each class of operation. For signed arithmetic it is a signed comparison. For unsigned arithmetic it is the carry out. For bitwise operations it is a zero test of the result. Bitwise operations leave the overflow flag as it was. When no operation is issued, all three registered outputs keep their values.

A second, independent path computes branch targets. It shifts a word offset left by two, sign-extends it, and adds it to the current instruction address plus four. The target is registered when a branch strobe is given and is held otherwise.

Top module: `int_alu_cc`

## Requirements
- R1: While `rst_n` is low, and after its release until the first issue or branch strobe, `result`, `ovf`, `cc` and `br_target` are all zero.
- R2: `op`=0 (signed add): `result` = s1 + s2 modulo 2^32. `ovf` is set when the signed sum overflows (the carry out of bit 31 differs from the carry out of bit 30). `cc` is set when s2 is less than the two's complement of s1 under a signed comparison.
- R3: `op`=1 (unsigned add): `result` = s1 + s2, and both `ovf` and `cc` equal the carry out of bit 31.
- R4: `op`=2 (signed subtract) and `op`=3 (unsigned subtract): `result` = s1 − s2, computed as s1 + ~s2 + 1. In the signed form, `ovf` is the signed overflow and `cc` is set when (−s2) < (−s1) under a signed comparison, both negations taken modulo 2^32. In the unsigned form, `ovf` = `cc` = the carry out of bit 31, which is 1 when s1 ≥ s2 unsigned.
- R5: When `use_imm` is 1, s1 is taken from `imm`: sign-extended for `op` 0–3 and zero-extended for `op` 4–5. When `use_imm` is 0, s1 is `reg_a`. s2 is always `reg_b`.
- R6: `op`=4 gives `result` = s1 & s2, and `op`=5 gives `result` = ~s1 & s2.
- R7: `op`=6 gives `result` = (imm << 16) & `reg_b`, and `op`=7 gives `result` = ~(imm << 16) & `reg_b`. Both use the immediate whatever the value of `use_imm`.
- R8: For `op` 4–7, `cc` is 1 exactly when the 32-bit result is zero.
- R9: An issued operation with `op` 4–7 leaves `ovf` unchanged.
- R10: While `issue` is 0, `result`, `ovf` and `cc` hold their values.
- R11: When `br_en` is 1, `br_target` becomes `pc` + 4 + sign_extend(`br_offset` << 2) after the next clock edge. This path is independent of `issue`.
- R12: While `br_en` is 0, `br_target` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Execute the operation on `op` in this cycle |
| op | input | 3 | Operation select (0 adds, 1 addu, 2 subs, 3 subu, 4 and, 5 andnot, 6 and-high, 7 andnot-high) |
| use_imm | input | 1 | Take the first operand from `imm` instead of `reg_a` |
| reg_a | input | 32 | First register operand |
| reg_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate constant |
| br_en | input | 1 | Capture a new branch target |
| br_offset | input | 26 | Signed word offset for the branch |
| pc | input | 32 | Address of the current control-transfer instruction |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered overflow flag |
| cc | output | 1 | Registered condition code |
| br_target | output | 32 | Registered branch target |

## Verification
Every result, flag and branch target is due exactly one rising edge after the cycle in which `issue` or `br_en` is presented. The bench drives its inputs on the falling edge and compares on the following falling edge, so each comparison sees the register loaded by the single edge in between. On idle cycles the bench compares against the previously expected values, which confirms that the registers hold. After each bitwise operation the bench compares `ovf` against the last arithmetic value it expects, which confirms that the flag was left alone.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADDS    = 3'd0,
        OP_ADDU    = 3'd1,
        OP_SUBS    = 3'd2,
        OP_SUBU    = 3'd3,
        OP_AND     = 3'd4,
        OP_ANDNOT  = 3'd5,
        OP_ANDH    = 3'd6,
        OP_ANDNOTH = 3'd7
    } alu_op_e;

    // bit 2 selects the bitwise class, bit 1 subtract, bit 0 unsigned
    function automatic logic op_is_logic(input alu_op_e o);
        return o[2];
    endfunction

    function automatic logic op_is_high(input alu_op_e o);
        return o[2] & o[1];
    endfunction

endpackage

// File: rtl/int_alu_operand.sv
module int_alu_operand
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  alu_op_e           op,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] s1
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;
    logic [DATA_W-1:0] imm_high;

    always_comb begin
        imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_zext = {{EXT_W{1'b0}}, imm};
        imm_high = imm_zext << IMM_W;
        if (op_is_high(op)) begin
            s1 = imm_high;
        end else if (use_imm) begin
            s1 = op_is_logic(op) ? imm_zext : imm_sext;
        end else begin
            s1 = reg_a;
        end
    end

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              c_msb,
    output logic              c_below
);
    localparam int LOW_W = DATA_W - 1;

    logic [LOW_W:0] low_sum;
    logic [1:0]     top_sum;

    always_comb begin
        low_sum = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
        c_below = low_sum[LOW_W];
        top_sum = {1'b0, a[DATA_W-1]} + {1'b0, b[DATA_W-1]} + {1'b0, c_below};
        c_msb   = top_sum[1];
        sum     = {top_sum[0], low_sum[LOW_W-1:0]};
    end

endmodule

// File: rtl/int_alu_branch.sv
module int_alu_branch #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 26
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] target
);
    localparam int SEXT_W = DATA_W - OFF_W - 2;
    localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

    logic [DATA_W-1:0] disp;

    always_comb begin
        disp   = {{SEXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        target = pc + STEP + disp;
    end

endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OFF_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [2:0]        op,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              br_en,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] result,
    output logic              ovf,
    output logic              cc,
    output logic [DATA_W-1:0] br_target
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              of;
        logic              cc;
        logic [DATA_W-1:0] tgt;
    } alu_state_t;

    alu_op_e    op_e;
    alu_state_t st_d, st_q;

    logic [DATA_W-1:0] s1, s2;
    logic [DATA_W-1:0] add_b, add_sum;
    logic              c_msb, c_below;
    logic [DATA_W-1:0] neg_s1, cmp_b;
    logic [DATA_W-1:0] log_y;
    logic [DATA_W-1:0] tgt_c;
    logic              is_sub, is_uns, is_log;
    logic              arith_of, arith_cc;

    assign op_e   = alu_op_e'(op);
    assign s2     = reg_b;
    assign is_sub = op[1];
    assign is_uns = op[0];
    assign is_log = op_is_logic(op_e);

    int_alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .op      (op_e),
        .use_imm (use_imm),
        .reg_a   (reg_a),
        .imm     (imm),
        .s1      (s1)
    );

    assign add_b = is_sub ? ~s2 : s2;

    int_alu_adder #(.DATA_W(DATA_W)) u_add (
        .a       (s1),
        .b       (add_b),
        .cin     (is_sub),
        .sum     (add_sum),
        .c_msb   (c_msb),
        .c_below (c_below)
    );

    int_alu_branch #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_br (
        .offset (br_offset),
        .pc     (pc),
        .target (tgt_c)
    );

    always_comb begin
        // flag computation and bitwise path
        neg_s1   = '0 - s1;
        cmp_b    = is_sub ? ('0 - s2) : s2;
        arith_of = is_uns ? c_msb : (c_msb ^ c_below);
        arith_cc = is_uns ? c_msb : ($signed(cmp_b) < $signed(neg_s1));
        log_y    = (op[0] ? ~s1 : s1) & s2;

        st_d = st_q;
        if (issue) begin
            st_d.res = is_log ? log_y : add_sum;
            st_d.cc  = is_log ? (log_y == '0) : arith_cc;
            if (!is_log) begin
                st_d.of = arith_of;
            end
        end
        if (br_en) begin
            st_d.tgt = tgt_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign ovf       = st_q.of;
    assign cc        = st_q.cc;
    assign br_target = st_q.tgt;

    AST_LOGIC_ZERO_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op[2]) |=> (cc == (result == '0))); // R8

    AST_UNSIGNED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !op[2] && op[0]) |=> (cc == ovf)); // R3

    AST_LOGIC_KEEPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op[2]) |=> $stable(ovf)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(result) && $stable(cc) && $stable(ovf))); // R10

    AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |=> $stable(br_target)); // R12

endmodule

// File: tb/int_alu_cc_test.sv
module int_alu_cc_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue;
    logic [2:0]  op;
    logic        use_imm;
    logic [31:0] reg_a, reg_b;
    logic [15:0] imm;
    logic        br_en;
    logic [25:0] br_offset;
    logic [31:0] pc;
    logic [31:0] result;
    logic        ovf, cc;
    logic [31:0] br_target;

    int errors = 0;
    int checks = 0;

    logic [31:0] e_res = '0;
    logic        e_of  = 1'b0;
    logic        e_cc  = 1'b0;
    logic [31:0] e_tgt = '0;

    always #10 clk = ~clk;

    int_alu_cc uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .use_imm(use_imm),
        .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .br_en(br_en),
        .br_offset(br_offset), .pc(pc), .result(result), .ovf(ovf), .cc(cc),
        .br_target(br_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] first_opnd(input logic [2:0] o, input logic ui,
                                               input logic [31:0] a, input logic [15:0] im);
        if (o >= 3'd6) return {im, 16'h0000};
        if (!ui) return a;
        if (o >= 3'd4) return {16'h0000, im};
        return {{16{im[15]}}, im};
    endfunction

    function automatic void model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                                  output logic [31:0] r, output logic f_of, output logic f_cc);
        logic [32:0] wide;
        case (o)
            3'd0: begin
                r = x + y;
                f_of = (x[31] == y[31]) && (r[31] != x[31]);
                f_cc = $signed(y) < $signed(32'd0 - x);
            end
            3'd1: begin
                wide = {1'b0, x} + {1'b0, y};
                r = wide[31:0]; f_of = wide[32]; f_cc = wide[32];
            end
            3'd2: begin
                r = x - y;
                f_of = (x[31] != y[31]) && (r[31] != x[31]);
                f_cc = $signed(32'd0 - y) < $signed(32'd0 - x);
            end
            3'd3: begin
                r = x - y; f_of = (x >= y); f_cc = (x >= y);
            end
            default: begin
                r = (o[0] ? ~x : x) & y;
                f_of = e_of; f_cc = (r == 32'd0);
            end
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4, 3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // drive at a falling edge, compare at the next falling edge
    task automatic step(input logic iss, input logic [2:0] o, input logic ui,
                        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                        input logic be, input logic [25:0] off, input logic [31:0] p,
                        input string note);
        logic [31:0] r;
        logic fo, fc;
        issue = iss; op = o; use_imm = ui; reg_a = a; reg_b = b; imm = im;
        br_en = be; br_offset = off; pc = p;
        @(negedge clk);
        if (iss) begin
            model(o, first_opnd(o, ui, a, im), b, r, fo, fc);
            e_res = r; e_cc = fc;
            if (!o[2]) e_of = fo;
        end
        if (be) e_tgt = p + 32'd4 + {{4{off[25]}}, off, 2'b00};
        if (iss) begin
            check({req_of(o), " result ", note}, result, e_res);
            check({o[2] ? "R8" : req_of(o), " cc ", note}, {31'd0, cc}, {31'd0, e_cc});
            check({o[2] ? "R9" : req_of(o), " ovf ", note}, {31'd0, ovf}, {31'd0, e_of});
        end else begin
            check({"R10 result hold ", note}, result, e_res);
            check({"R10 flags hold ", note}, {30'd0, ovf, cc}, {30'd0, e_of, e_cc});
        end
        check({be ? "R11" : "R12", " target ", note}, br_target, e_tgt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; issue = 1'b0; op = 3'd0; use_imm = 1'b0; reg_a = 32'h1234_5678;
        reg_b = 32'h9abc_def0; imm = 16'h5555; br_en = 1'b1; br_offset = 26'h1;
        pc = 32'h100;
        issue = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 result in reset", result, 32'd0);
        check("R1 flags in reset", {30'd0, ovf, cc}, 32'd0);
        check("R1 target in reset", br_target, 32'd0);
        issue = 1'b0; br_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result after release", result, 32'd0);
        check("R1 target after release", br_target, 32'd0);

        // directed corners
        step(1, 3'd0, 0, 32'h7fff_ffff, 32'h0000_0001, 16'h0, 0, '0, '0, "signed overflow");
        step(1, 3'd4, 0, 32'h0000_ff00, 32'h0000_00ff, 16'h0, 0, '0, '0, "and zero keeps ovf");
        step(0, 3'd0, 0, 32'h1, 32'h1, 16'h0, 0, '0, '0, "idle");
        step(1, 3'd1, 0, 32'hffff_ffff, 32'h0000_0001, 16'h0, 0, '0, '0, "unsigned carry");
        step(1, 3'd0, 0, 32'h8000_0000, 32'h8000_0000, 16'h0, 0, '0, '0, "min plus min");
        step(1, 3'd0, 0, 32'h0000_0005, 32'hffff_fff0, 16'h0, 0, '0, '0, "cc below neg");
        step(1, 3'd2, 0, 32'h8000_0000, 32'h0000_0001, 16'h0, 0, '0, '0, "signed sub ovf");
        step(1, 3'd2, 0, 32'h0000_0003, 32'h0000_0007, 16'h0, 0, '0, '0, "signed sub less");
        step(1, 3'd3, 0, 32'h0000_0007, 32'h0000_0007, 16'h0, 0, '0, '0, "unsigned sub equal");
        step(1, 3'd3, 0, 32'h0000_0003, 32'h0000_0007, 16'h0, 0, '0, '0, "unsigned sub borrow");
        step(1, 3'd0, 1, 32'hdead_beef, 32'h0000_0010, 16'hfff0, 0, '0, '0, "R5 sign-extended imm");
        step(1, 3'd4, 1, 32'hdead_beef, 32'hffff_ffff, 16'h8001, 0, '0, '0, "R5 zero-extended imm");
        step(1, 3'd5, 1, 32'h0, 32'hffff_0000, 16'hffff, 0, '0, '0, "R5 andnot imm");
        step(1, 3'd6, 0, 32'hffff_ffff, 32'h1234_ffff, 16'h00f0, 0, '0, '0, "R7 andh ignores reg_a");
        step(1, 3'd7, 1, 32'h0, 32'hffff_ffff, 16'hffff, 0, '0, '0, "R7 andnoth zero");
        step(0, 3'd1, 0, 32'h0, 32'h0, 16'h0, 1, 26'h3ff_ffff, 32'h0000_1000, "backward branch");
        step(0, 3'd1, 0, 32'h0, 32'h0, 16'h0, 1, 26'h1ff_ffff, 32'h0000_0000, "max forward");
        step(0, 3'd1, 0, 32'h0, 32'h0, 16'h0, 0, 26'h0000_123, 32'h5555_0000, "branch idle");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            logic [2:0]  ro;
            ra = $urandom();
            rb = $urandom();
            ro = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) rb = '0;
            if ($urandom_range(0, 7) == 0) rb = ra;
            step(($urandom_range(0, 5) != 0), ro, 1'($urandom_range(0, 1)), ra, rb,
                 16'($urandom()), 1'($urandom_range(0, 1)), 26'($urandom()), $urandom(),
                 "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule